// File: doc/BRIEF.md
# Stepped Digital Gain Control Loop

This block holds the envelope of a complex baseband signal close to a programmable power target. On each cycle where the step enable is high, it takes the current I/Q sample and forms the squared magnitude I² + Q². That value is the power level of the envelope, so a ratio of squared values is a ratio in dB. No square root and no logarithm are computed. The squared magnitude is compared with five thresholds, each a fixed fraction of the target. The result picks a gain move of −5 dB, −1 dB, none, +1 dB or +5 dB. The gain setting is kept between 0 dB and −96 dB.

The loop sits after the variable-gain stage it controls, and the gain output drives that stage. A freeze input stops all updates, for example once the preamble has passed. The settled flag shows that the loop has stayed inside its ±1 dB window for two step ticks in a row.

Top module: `agc_step_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `gain_db` reads 0 and `settled` reads 0.
- R2: Let P = I² + Q². When P·256 > T·810, where T is `tgt_pow`, the next step lowers the gain by 5 dB. This is the more-than-+5 dB region.
- R3: When T·322 < P·256 ≤ T·810, the next step lowers the gain by 1 dB.
- R4: When T·203 ≤ P·256 ≤ T·322, the ±1 dB dead zone, the step leaves the gain unchanged.
- R5: When T·81 ≤ P·256 < T·203, the step raises the gain by 1 dB. When P·256 < T·81, it raises the gain by 5 dB.
- R6: The gain never goes above 0 dB or below −96 dB. A step that would cross a limit stops at that limit.
- R7: The gain changes only on a clock edge that samples `tick_en` high and `freeze` low. The new value is visible from that edge onward.
- R8: While `freeze` is high, `gain_db` and `settled` keep their values whatever the samples and `tick_en` do.
- R9: `settled` rises on the second consecutive counted step that falls in the dead zone. It clears on the first counted step outside the dead zone.
- R10: `gain_db` is an 8-bit two's-complement value in whole dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Step enable; one gain update per high cycle |
| freeze | input | 1 | Holds the gain and the settled flag when high |
| i_samp | input | 12 | In-phase sample, signed |
| q_samp | input | 12 | Quadrature sample, signed |
| tgt_pow | input | 24 | Target squared magnitude |
| gain_db | output | 8 | Gain setting in dB, signed, range −96..0 |
| settled | output | 1 | High after two consecutive dead-zone steps |

## Verification
The bench places samples exactly on the threshold boundaries (P = 810 and P = 81 with T = 256, and just below 81). An off-by-one comparison would show up there as the wrong step size. It drives the gain from a level 1 dB below zero into the top limit, and it walks the gain down in 5 dB steps to the −96 dB floor, which is not a multiple of five. A design with wrapping or missing clamps would show a positive gain or a value below −96. The bench also checks that cycles without a tick, and cycles with freeze high, leave both outputs unchanged. Finally it checks that one dead-zone step alone does not raise `settled`, which catches a counter that fires one step early.

// File: rtl/agc_step_pkg.sv
package agc_step_pkg;

    // Zones ordered from loudest to quietest
    typedef enum logic [2:0] {
        Z_CUT5    = 3'd0,
        Z_CUT1    = 3'd1,
        Z_HOLD_HI = 3'd2,
        Z_HOLD_LO = 3'd3,
        Z_ADD1    = 3'd4,
        Z_ADD5    = 3'd5
    } zone_e;

    // Threshold ratios against the target, scaled by 2^RATIO_SHIFT
    localparam int unsigned RATIO_SHIFT = 8;
    localparam int unsigned RATIO_W     = 10;
    localparam int unsigned N_THR       = 5;
    localparam int unsigned RATIO_TAB [N_THR] = '{810, 322, 256, 203, 81};

endpackage

// File: rtl/agc_pow_est.sv
module agc_pow_est #(
    parameter int unsigned SAMPLE_W = 12,
    localparam int unsigned POW_W   = 2 * SAMPLE_W
) (
    input  logic signed [SAMPLE_W-1:0] i_in,
    input  logic signed [SAMPLE_W-1:0] q_in,
    output logic        [POW_W-1:0]    pow_out
);

    logic signed [POW_W-1:0] sq_i;
    logic signed [POW_W-1:0] sq_q;

    always_comb begin
        sq_i    = i_in * i_in;
        sq_q    = q_in * q_in;
        pow_out = $unsigned(sq_i) + $unsigned(sq_q);
    end

endmodule

// File: rtl/agc_zone_cmp.sv
module agc_zone_cmp
    import agc_step_pkg::*;
#(
    parameter int unsigned POW_W = 24,
    localparam int unsigned CMP_W = POW_W + RATIO_W + 1
) (
    input  logic [POW_W-1:0] pow_in,
    input  logic [POW_W-1:0] tgt_in,
    output zone_e            zone
);

    logic [CMP_W-1:0] lhs;
    logic [N_THR-1:0] hit;

    assign lhs = CMP_W'(pow_in) << RATIO_SHIFT;

    for (genvar g = 0; g < N_THR; g++) begin : g_thr
        logic [CMP_W-1:0] rhs;
        assign rhs = CMP_W'(tgt_in) * CMP_W'(RATIO_TAB[g]);
        if (g < 2) begin : g_strict
            // upper thresholds: boundary value stays in the quieter zone
            assign hit[g] = lhs > rhs;
        end else begin : g_incl
            assign hit[g] = lhs >= rhs;
        end
    end

    always_comb begin
        if (hit[0])      zone = Z_CUT5;
        else if (hit[1]) zone = Z_CUT1;
        else if (hit[2]) zone = Z_HOLD_HI;
        else if (hit[3]) zone = Z_HOLD_LO;
        else if (hit[4]) zone = Z_ADD1;
        else             zone = Z_ADD5;
    end

endmodule

// File: rtl/agc_step_ctrl.sv
module agc_step_ctrl
    import agc_step_pkg::*;
#(
    parameter int unsigned SAMPLE_W     = 12,
    parameter int unsigned GAIN_W       = 8,
    parameter int          GAIN_MIN     = -96,
    parameter int          COARSE_DB    = 5,
    parameter int          FINE_DB      = 1,
    parameter int unsigned SETTLE_TICKS = 2,
    localparam int unsigned POW_W       = 2 * SAMPLE_W,
    localparam int unsigned CNT_W       = $clog2(SETTLE_TICKS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       freeze,
    input  logic signed [SAMPLE_W-1:0] i_samp,
    input  logic signed [SAMPLE_W-1:0] q_samp,
    input  logic        [POW_W-1:0]    tgt_pow,
    output logic signed [GAIN_W-1:0]   gain_db,
    output logic                       settled
);

    typedef struct packed {
        logic signed [GAIN_W-1:0] gain;
        logic [CNT_W-1:0]         cnt;
        logic                     settled;
    } st_t;

    st_t st_d, st_q;

    logic [POW_W-1:0] pow;
    zone_e            zone;
    logic             step_ok;
    logic             in_dz;
    int               step_db;
    int               gain_nxt;

    agc_pow_est #(.SAMPLE_W(SAMPLE_W)) pow_i (
        .i_in    (i_samp),
        .q_in    (q_samp),
        .pow_out (pow)
    );

    agc_zone_cmp #(.POW_W(POW_W)) cmp_i (
        .pow_in (pow),
        .tgt_in (tgt_pow),
        .zone   (zone)
    );

    assign step_ok = tick_en && !freeze;
    assign in_dz   = (zone == Z_HOLD_HI) || (zone == Z_HOLD_LO);

    always_comb begin
        st_d = st_q;
        unique case (zone)
            Z_CUT5:  step_db = -COARSE_DB;
            Z_CUT1:  step_db = -FINE_DB;
            Z_ADD1:  step_db = FINE_DB;
            Z_ADD5:  step_db = COARSE_DB;
            default: step_db = 0;
        endcase
        gain_nxt = int'(st_q.gain) + step_db;
        if (gain_nxt > 0)        gain_nxt = 0;
        if (gain_nxt < GAIN_MIN) gain_nxt = GAIN_MIN;
        if (step_ok) begin
            st_d.gain = GAIN_W'(gain_nxt);
            if (in_dz) begin
                if (st_q.cnt != CNT_W'(SETTLE_TICKS))
                    st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
            end
            st_d.settled = (st_d.cnt == CNT_W'(SETTLE_TICKS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gain_db = st_q.gain;
    assign settled = st_q.settled;

    // R6
    gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gain_db) <= 0) && (int'(gain_db) >= GAIN_MIN));

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(gain_db) && $stable(settled)));

    // R7
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(gain_db));

    // R4
    dead_zone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && in_dz) |=> $stable(gain_db));

    // R2
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_ok |=> ((int'(gain_db) - int'($past(gain_db)) <= COARSE_DB) &&
                     (int'(gain_db) - int'($past(gain_db)) >= -COARSE_DB)));

    // R9
    settle_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> $past(step_ok && in_dz));

endmodule

// File: tb/agc_step_ctrl_tb.sv
module agc_step_ctrl_tb_top;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick_en = 1'b0;
    logic               freeze = 1'b0;
    logic signed [11:0] i_samp = '0;
    logic signed [11:0] q_samp = '0;
    logic        [23:0] tgt_pow = 24'd10000;
    logic signed [7:0]  gain_db;
    logic               settled;

    int n_tot  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    agc_step_ctrl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .freeze  (freeze),
        .i_samp  (i_samp),
        .q_samp  (q_samp),
        .tgt_pow (tgt_pow),
        .gain_db (gain_db),
        .settled (settled)
    );

    // Table walk with target 10000: +5dB above P>31640, +1dB above P>12578,
    // dead zone 7930..12578, -5dB below P<3165
    localparam int NV = 10;
    localparam int VI [NV] = '{100,  60, 200, 100, -120,   0, 30, 30,   0,  0};
    localparam int VQ [NV] = '{  0,  80,   0, 100,    0, -85, 40, 40, 112, 89};
    localparam int EG [NV] = '{  0,   0,  -5,  -6,   -7,  -6, -1,  0,   0,  0};
    localparam int ES [NV] = '{  0,   1,   0,   0,    0,   0,  0,  0,   0,  0};
    // Tags: R4 v0,v1,v8; R9 v1; R2 v2; R3 v3,v4; R5 v5,v6; R6 v7,v9

    task automatic check(input string req, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_once(input int i, input int q);
        @(negedge clk);
        i_samp  = 12'(i);
        q_samp  = 12'(q);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tot++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 gain in reset", int'(gain_db), 0);
        check("R1 settled in reset", int'(settled), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 gain after reset", int'(gain_db), 0);

        for (int v = 0; v < NV; v++) begin
            tick_once(VI[v], VQ[v]);
            check($sformatf("R2-table v%0d gain", v), int'(gain_db), EG[v]);
            check($sformatf("R9 table v%0d settled", v), int'(settled), ES[v]);
        end

        // R7: no tick, no change
        @(negedge clk);
        i_samp = 12'sd2047;
        q_samp = 12'sd2047;
        repeat (3) @(negedge clk);
        check("R7 no tick hold", int'(gain_db), 0);

        // R9: one dead-zone step is not enough, two are
        tick_once(100, 0);
        check("R9 one dead step", int'(settled), 0);
        tick_once(100, 0);
        check("R9 two dead steps", int'(settled), 1);

        // R8: freeze holds gain and settled
        @(negedge clk);
        freeze = 1'b1;
        tick_once(2047, 2047);
        tick_once(0, 0);
        check("R8 freeze gain", int'(gain_db), 0);
        check("R8 freeze settled", int'(settled), 1);
        @(negedge clk);
        freeze = 1'b0;

        tick_once(2047, 2047);
        check("R2 coarse cut", int'(gain_db), -5);
        check("R9 cleared out of zone", int'(settled), 0);

        // R6 lower clamp at -96
        for (int k = 0; k < 20; k++) tick_once(2047, 2047);
        check("R6 floor clamp", int'(gain_db), -96);

        // R5 fine raise from floor
        tick_once(0, 85);
        check("R5 fine raise", int'(gain_db), -95);

        // Boundaries with target 256: thresholds equal the ratio values
        @(negedge clk);
        tgt_pow = 24'd256;
        tick_once(9, 0);    // P=81: R5 fine raise
        check("R5 boundary P=81", int'(gain_db), -94);
        tick_once(8, 4);    // P=80: R5 coarse raise
        check("R5 boundary P=80", int'(gain_db), -89);
        tick_once(27, 9);   // P=810: R3 fine cut
        check("R3 boundary P=810", int'(gain_db), -90);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset gain", int'(gain_db), 0);
        check("R1 mid-run reset settled", int'(settled), 0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule